// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps a running time-of-day for a precision time protocol node. The time is made of an unsigned 32-bit seconds count and a 31-bit subseconds count. The subseconds count is a binary fraction of one second, with 2^31 counts per second, so one count is about 0.466 ns. Taken together, `{seconds, subseconds}` is a single 63-bit number in units of 2^-31 s.

In coarse mode the time grows by a programmable subsecond increment on every clock. In fine mode a 32-bit phase accumulator takes in a programmable addend on every clock, and the time grows by the increment only on clocks where that accumulator carries out. Software can therefore trim the counting rate in steps of 2^-32.

Software can also correct the time directly through an update value. This value is a seconds word plus a 32-bit word whose top bit is a sign and whose lower 31 bits are subseconds. A load strobe writes the update value into the time. An adjust strobe adds the update value to the time, or subtracts it when the sign is set. Each strobe is answered by a one-cycle done pulse.

Top module: `ptp_clock_core`

## Requirements
- R1: After reset, seconds, subseconds, both done flags and the phase accumulator are all zero.
- R2: In coarse mode (`fine_mode_i`=0), on every clock without a strobe, the 63-bit time `{sec_o, sub_o}` grows by `incr_i`.
- R3: Subseconds stay below 2^31. When a step or an add brings them to 2^31 or above, they wrap modulo 2^31 and one is carried into seconds. Seconds wrap modulo 2^32.
- R4: On a clock with `init_i`=1, `sec_o` takes `upd_sec_i` and `sub_o` takes `upd_word_i[30:0]`. The sign bit `upd_word_i[31]` is ignored.
- R5: On a clock with `adjust_i`=1 and `upd_word_i[31]`=0, the time becomes `{sec,sub} + {upd_sec_i, upd_word_i[30:0]}`, taken modulo 2^63.
- R6: On a clock with `adjust_i`=1 and `upd_word_i[31]`=1, that value is subtracted instead. A negative subseconds result gets 2^31 added and borrows one from seconds; the whole result is taken modulo 2^63.
- R7: In fine mode, on each clock the accumulator takes `acc + addend_i` modulo 2^32. The time steps by `incr_i` only on clocks where that sum is 2^32 or more; otherwise, without a strobe, the time holds.
- R8: In coarse mode `addend_i` has no effect: the accumulator holds its value, and the time steps on every clock.
- R9: Priority within one clock is load, then adjust, then the normal step. A clock with either strobe gets no increment.
- R10: `init_done_o` is high for exactly the clock after a load clock. `adjust_done_o` is high for exactly the clock after an adjust clock that no load overrode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fine_mode_i | input | 1 | 1 selects accumulator-gated stepping |
| addend_i | input | 32 | Phase accumulator addend |
| incr_i | input | 8 | Subsecond increment per step |
| upd_sec_i | input | 32 | Update value, seconds |
| upd_word_i | input | 32 | Update value: bit 31 is the sign, bits 30:0 are the subseconds |
| init_i | input | 1 | Load strobe |
| adjust_i | input | 1 | Signed adjust strobe |
| sec_o | output | 32 | Current seconds |
| sub_o | output | 31 | Current subseconds |
| init_done_o | output | 1 | Pulse one clock after a load |
| adjust_done_o | output | 1 | Pulse one clock after an adjust |

## Verification
The adjust path is swept across a grid of starting times and offsets. The starting subseconds are 0, 1, 2^30 and 2^31-1, the starting seconds sit at 0 and at the all-ones wrap point, and both signs are used, so every carry, borrow and seconds wrap is reached. Coarse stepping is run with increments of 0, 1, 7 and 255 from times just under a second boundary, which separates a correct carry from a lost or doubled one. Fine mode is run with addends of 0, a quarter of full scale, just over half, all ones and an irregular value; these tell a missing carry gate apart from an off-by-one in accumulator phase. Addend changes in coarse mode, sign-set loads and colliding load and adjust strobes show whether the priority and ignore rules are met.

// File: rtl/ptp_clock_pkg.sv
package ptp_clock_pkg;
  parameter int SEC_W = 32;
  parameter int SUB_W = 31;
  localparam int TOT_W = SEC_W + SUB_W;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [SUB_W-1:0] sub;
  } ptp_time_t;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2,
    OP_ADJ  = 2'd3
  } ptp_op_e;

  // Add a seconds/subseconds pair, carrying out of the subsecond fraction.
  function automatic ptp_time_t time_add(ptp_time_t t, logic [SUB_W-1:0] d_sub,
                                         logic [SEC_W-1:0] d_sec);
    ptp_time_t r;
    logic [SUB_W:0] s;
    s     = {1'b0, t.sub} + {1'b0, d_sub};
    r.sub = s[SUB_W-1:0];
    r.sec = t.sec + d_sec + SEC_W'(s[SUB_W]);
    return r;
  endfunction

  // Subtract a seconds/subseconds pair; a negative fraction borrows a second.
  function automatic ptp_time_t time_sub(ptp_time_t t, logic [SUB_W-1:0] d_sub,
                                         logic [SEC_W-1:0] d_sec);
    ptp_time_t r;
    logic [SUB_W:0] s;
    s     = {1'b0, t.sub} - {1'b0, d_sub};
    r.sub = s[SUB_W-1:0];
    r.sec = t.sec - d_sec - SEC_W'(s[SUB_W]);
    return r;
  endfunction
endpackage

// File: rtl/ptp_rate_gen.sv
module ptp_rate_gen #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w  = {1'b0, acc_q} + {1'b0, addend_i};
  assign tick_o = fine_i ? sum_w[ACC_W] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (fine_i) acc_q <= sum_w[ACC_W-1:0];
  end
endmodule

// File: rtl/ptp_time_next.sv
module ptp_time_next
  import ptp_clock_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  ptp_time_t        cur_i,
  input  logic             tick_i,
  input  logic             init_i,
  input  logic             adjust_i,
  input  logic [SEC_W-1:0] upd_sec_i,
  input  logic [SUB_W:0]   upd_word_i,
  input  logic [INC_W-1:0] incr_i,
  output ptp_time_t        nxt_o,
  output ptp_op_e          op_o
);
  logic             neg_w;
  logic [SUB_W-1:0] mag_w;

  assign neg_w = upd_word_i[SUB_W];
  assign mag_w = upd_word_i[SUB_W-1:0];

  always_comb begin
    op_o  = OP_HOLD;
    nxt_o = cur_i;
    if (init_i) begin
      op_o      = OP_LOAD;
      nxt_o.sec = upd_sec_i;
      nxt_o.sub = mag_w;
    end else if (adjust_i) begin
      op_o  = OP_ADJ;
      nxt_o = neg_w ? time_sub(cur_i, mag_w, upd_sec_i)
                    : time_add(cur_i, mag_w, upd_sec_i);
    end else if (tick_i) begin
      op_o  = OP_STEP;
      nxt_o = time_add(cur_i, SUB_W'(incr_i), '0);
    end
  end
endmodule

// File: rtl/ptp_clock_core.sv
module ptp_clock_core
  import ptp_clock_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_mode_i,
  input  logic [ACC_W-1:0] addend_i,
  input  logic [INC_W-1:0] incr_i,
  input  logic [SEC_W-1:0] upd_sec_i,
  input  logic [SUB_W:0]   upd_word_i,
  input  logic             init_i,
  input  logic             adjust_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             init_done_o,
  output logic             adjust_done_o
);
  ptp_time_t time_q, time_nxt;
  ptp_op_e   op_w;
  logic      tick_w;

  ptp_rate_gen #(.ACC_W(ACC_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .fine_i   (fine_mode_i),
    .addend_i (addend_i),
    .tick_o   (tick_w)
  );

  ptp_time_next #(.INC_W(INC_W)) u_next (
    .cur_i      (time_q),
    .tick_i     (tick_w),
    .init_i     (init_i),
    .adjust_i   (adjust_i),
    .upd_sec_i  (upd_sec_i),
    .upd_word_i (upd_word_i),
    .incr_i     (incr_i),
    .nxt_o      (time_nxt),
    .op_o       (op_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q        <= '0;
      init_done_o   <= 1'b0;
      adjust_done_o <= 1'b0;
    end else begin
      time_q        <= time_nxt;
      init_done_o   <= (op_w == OP_LOAD);
      adjust_done_o <= (op_w == OP_ADJ);
    end
  end

  assign sec_o = time_q.sec;
  assign sub_o = time_q.sub;
endmodule

// File: rtl/ptp_clock_core_chk.sv
module ptp_clock_core_chk
  import ptp_clock_pkg::*;
#(
  parameter int INC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fine_mode_i,
  input logic [INC_W-1:0] incr_i,
  input logic [SEC_W-1:0] upd_sec_i,
  input logic [SUB_W:0]   upd_word_i,
  input logic             init_i,
  input logic             adjust_i,
  input logic [SEC_W-1:0] sec_o,
  input logic [SUB_W-1:0] sub_o,
  input logic             init_done_o,
  input logic             adjust_done_o,
  input logic             tick_w
);
  logic [TOT_W-1:0] tot_w, upd_mag_w;
  assign tot_w     = {sec_o, sub_o};
  assign upd_mag_w = {upd_sec_i, upd_word_i[SUB_W-1:0]};

  // R2
  coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_mode_i && !init_i && !adjust_i |=> tot_w == $past(tot_w + TOT_W'(incr_i)));
  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> tot_w == $past(upd_mag_w));
  // R5
  adjust_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adjust_i && !init_i && !upd_word_i[SUB_W] |=> tot_w == $past(tot_w + upd_mag_w));
  // R6
  adjust_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adjust_i && !init_i && upd_word_i[SUB_W] |=> tot_w == $past(tot_w - upd_mag_w));
  // R7
  fine_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_mode_i && !tick_w && !init_i && !adjust_i |=> $stable(tot_w));
  // R8
  coarse_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_mode_i |-> tick_w);
  // R10
  init_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> init_done_o);
  // R10
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i |=> !init_done_o);
  // R10
  adj_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adjust_i && !init_i |=> adjust_done_o);
  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_done_o, adjust_done_o}));
endmodule

bind ptp_clock_core ptp_clock_core_chk #(.INC_W(INC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fine_mode_i   (fine_mode_i),
  .incr_i        (incr_i),
  .upd_sec_i     (upd_sec_i),
  .upd_word_i    (upd_word_i),
  .init_i        (init_i),
  .adjust_i      (adjust_i),
  .sec_o         (sec_o),
  .sub_o         (sub_o),
  .init_done_o   (init_done_o),
  .adjust_done_o (adjust_done_o),
  .tick_w        (tick_w)
);

// File: tb/test_ptp_clock_core.sv
module test_ptp_clock_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fine_mode_i = 1'b0;
  logic [31:0] addend_i = '0;
  logic [7:0]  incr_i = '0;
  logic [31:0] upd_sec_i = '0;
  logic [31:0] upd_word_i = '0;
  logic        init_i = 1'b0;
  logic        adjust_i = 1'b0;
  logic [31:0] sec_o;
  logic [30:0] sub_o;
  logic        init_done_o, adjust_done_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [62:0] m_tot = '0;
  logic [31:0] m_acc = '0;
  logic        m_idone = 1'b0, m_adone = 1'b0;

  always #2 clk = ~clk;

  ptp_clock_core i_ptp_clock_core (
    .clk, .rst_n, .fine_mode_i, .addend_i, .incr_i, .upd_sec_i, .upd_word_i,
    .init_i, .adjust_i, .sec_o, .sub_o, .init_done_o, .adjust_done_o
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Advance one clock: update the reference at the edge, compare away from it.
  task automatic cyc();
    logic [32:0] s;
    logic        stp;
    @(posedge clk);
    stp = 1'b1;
    if (fine_mode_i) begin
      s     = {1'b0, m_acc} + {1'b0, addend_i};
      m_acc = s[31:0];
      stp   = s[32];
    end
    m_idone = init_i;
    m_adone = adjust_i && !init_i;
    if (init_i)        m_tot = {upd_sec_i, upd_word_i[30:0]};
    else if (adjust_i) m_tot = upd_word_i[31] ? m_tot - {upd_sec_i, upd_word_i[30:0]}
                                               : m_tot + {upd_sec_i, upd_word_i[30:0]};
    else if (stp)      m_tot = m_tot + 63'(incr_i);
    @(negedge clk);
    check({sec_o, sub_o} == m_tot, cur_req, 64'({sec_o, sub_o}), 64'(m_tot));
    check({init_done_o, adjust_done_o} == {m_idone, m_adone}, {cur_req, "/R10"},
          64'({init_done_o, adjust_done_o}), 64'({m_idone, m_adone}));
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] w);
    upd_sec_i = s; upd_word_i = w; init_i = 1'b1;
    cyc();
    init_i = 1'b0;
  endtask

  function automatic logic [30:0] pick_sub(input int i);
    case (i)
      0: return 31'd0;
      1: return 31'd1;
      2: return 31'h4000_0000;
      default: return 31'h7FFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] pick_add(input int i);
    case (i)
      0: return 32'h0;
      1: return 32'h4000_0000;
      2: return 32'h8000_0001;
      3: return 32'hFFFF_FFFF;
      default: return 32'h1234_5678;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({sec_o, sub_o, init_done_o, adjust_done_o} == '0, "R1",
          64'({sec_o, sub_o}), 64'd0);
    rst_n = 1'b1;

    // R2 and R3: coarse stepping across a second boundary, several increments
    for (int k = 0; k < 4; k++) begin
      cur_req = "R2/R3";
      incr_i = (k == 0) ? 8'd0 : (k == 1) ? 8'd1 : (k == 2) ? 8'd7 : 8'd255;
      load(32'hFFFF_FFFF, 32'h7FFF_FFF0);
      repeat (6) cyc();
    end

    // R4: load ignores the sign bit
    cur_req = "R4";
    load(32'h0000_1234, 32'hFFFF_FFFF);
    check(sub_o == 31'h7FFF_FFFF, "R4", 64'(sub_o), 64'h7FFF_FFFF);

    // R5, R6, R3: adjust grid across carry, borrow and seconds wrap
    incr_i = 8'd3;
    for (int sp = 0; sp < 4; sp++)
      for (int se = 0; se < 2; se++)
        for (int op = 0; op < 4; op++)
          for (int sg = 0; sg < 2; sg++)
            for (int dsec = 0; dsec < 2; dsec++) begin
              cur_req = "R4";
              load(se ? 32'hFFFF_FFFF : 32'h0, {1'b0, pick_sub(sp)});
              cur_req = sg ? "R6" : "R5";
              upd_sec_i = dsec ? 32'h1 : 32'h0;
              upd_word_i = {sg[0], pick_sub(op)};
              adjust_i = 1'b1;
              cyc();
              adjust_i = 1'b0;
              cur_req = "R3";
              cyc();
            end

    // R9: load wins over adjust in one clock
    cur_req = "R9";
    upd_sec_i = 32'd77; upd_word_i = 32'h8000_0010;
    init_i = 1'b1; adjust_i = 1'b1;
    cyc();
    init_i = 1'b0; adjust_i = 1'b0;
    check({sec_o, sub_o} == {32'd77, 31'h10}, "R9", 64'({sec_o, sub_o}),
          64'({32'd77, 31'h10}));
    cyc();

    // R7: fine mode with various addends
    incr_i = 8'd9;
    fine_mode_i = 1'b1;
    for (int a = 0; a < 5; a++) begin
      cur_req = "R7";
      addend_i = pick_add(a);
      repeat (40) cyc();
    end

    // R8: addend wiggles in coarse mode; accumulator phase must stay held
    fine_mode_i = 1'b0;
    for (int i = 0; i < 30; i++) begin
      cur_req = "R8";
      addend_i = addend_i * 32'd1664525 + 32'd1013904223;
      cyc();
    end
    fine_mode_i = 1'b1;
    addend_i = 32'h2000_0000;
    cur_req = "R8";
    repeat (16) cyc();

    // R9: strobe clock in fine mode gets no step even on a carry
    cur_req = "R9";
    addend_i = 32'hFFFF_FFFF;
    upd_sec_i = 32'd0; upd_word_i = 32'h0000_0005; adjust_i = 1'b1;
    cyc();
    adjust_i = 1'b0;
    repeat (4) cyc();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule